// File: doc/BRIEF.md
# Three-Heads Coin Game Scorer

This block keeps score in a coin-toss game and is built as a synchronous Mealy state machine. On every clock edge it takes one toss symbol: a head, a tail, or "no toss". The game is won when a set number of heads arrive back to back. The default is three. The game is lost as soon as a tail turns up before that run is complete. After a win or a loss the machine goes back to its starting position, so the next game begins on the next toss.

The toss arrives as a valid bit with a value bit beside it. The result is computed from the current position and the current toss. It is then captured in flip-flops on the same edge that updates the position. A win or lose pulse therefore appears one cycle after the toss that caused it and lasts exactly one cycle. The current position, meaning the number of heads collected so far, is brought out so it can be observed.

Top module: `coin_streak_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the position is set to 0 heads and both `win_o` and `lose_o` read 0 after that edge, whatever toss is presented.
- R2: A head (`toss_valid`=1, `toss_head`=1) taken while the position is below RUN_LEN-1 raises the position by one and produces no result.
- R3: A head taken at position RUN_LEN-1 (2 by default) sets `win_o` to 1 for the next cycle and returns the position to 0.
- R4: A tail (`toss_valid`=1, `toss_head`=0) taken at any position sets `lose_o` to 1 for the next cycle and returns the position to 0.
- R5: When `toss_valid` is 0 (no toss), the position is unchanged and neither result is produced, whatever the value of `toss_head`.
- R6: `win_o` and `lose_o` are never high in the same cycle, and each stays high for exactly one cycle per result.
- R7: The outputs are registered. A toss presented between edges does not change `win_o`, `lose_o` or `state_o` until the next rising edge.
- R8: `state_o` always stays in the range 0 to RUN_LEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| toss_valid | input | 1 | 1 means a toss is present this cycle; 0 means no toss |
| toss_head | input | 1 | Toss value: 1 head, 0 tail; ignored when `toss_valid` is 0 |
| win_o | output | 1 | One-cycle pulse: the run of heads is complete |
| lose_o | output | 1 | One-cycle pulse: a tail ended the game |
| state_o | output | CNT_W (2) | Heads collected so far in the current game |

## Verification
The bound checker tests the transition rules (R2 to R5) on every cycle. It relates the position and the result after each edge to the toss and the position before that edge. On every cycle it also checks that the two results are exclusive, that the position stays in range, and that reset clears everything. Some behaviour can only be shown by the bench's scenarios. These are: the outputs holding still between edges, the pulse dropping after one cycle when the game moves on, and the directed tail-then-three-heads game. The bench also compares a long seeded random toss stream against its own model of the game.

// File: rtl/coin_streak_pkg.sv
package coin_streak_pkg;

  // Decoded toss symbol
  typedef enum logic [1:0] {
    SYM_ABSENT = 2'd0,
    SYM_HEAD   = 2'd1,
    SYM_TAIL   = 2'd2
  } toss_sym_t;

  // Result produced on a transition
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_WIN  = 2'd1,
    RES_LOSE = 2'd2
  } result_t;

  // Map the valid/value pair onto a symbol
  function automatic toss_sym_t classify_toss(input logic valid, input logic head);
    if (!valid)    return SYM_ABSENT;
    else if (head) return SYM_HEAD;
    else           return SYM_TAIL;
  endfunction

endpackage

// File: rtl/toss_decoder.sv
module toss_decoder
  import coin_streak_pkg::*;
(
  input  logic      valid_i,
  input  logic      head_i,
  output toss_sym_t sym_o
);

  always_comb begin
    sym_o = classify_toss(valid_i, head_i);
  end

endmodule

// File: rtl/streak_next.sv
module streak_next
  import coin_streak_pkg::*;
#(
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = $clog2(RUN_LEN)
) (
  input  logic [CNT_W-1:0] cur_i,
  input  toss_sym_t        sym_i,
  output logic [CNT_W-1:0] nxt_o,
  output result_t          res_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  always_comb begin
    nxt_o = cur_i;
    res_o = RES_NONE;
    unique case (sym_i)
      SYM_HEAD: begin
        if (cur_i >= LAST) begin
          nxt_o = '0;
          res_o = RES_WIN;
        end else begin
          nxt_o = cur_i + 1'b1;
        end
      end
      SYM_TAIL: begin
        nxt_o = '0;
        res_o = RES_LOSE;
      end
      default: begin
        nxt_o = cur_i;
        res_o = RES_NONE;
      end
    endcase
  end

endmodule

// File: rtl/streak_regs.sv
module streak_regs
  import coin_streak_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] nxt_i,
  input  result_t          res_i,
  output logic [CNT_W-1:0] state_q,
  output logic             win_q,
  output logic             lose_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      win_q   <= 1'b0;
      lose_q  <= 1'b0;
    end else begin
      state_q <= nxt_i;
      win_q   <= (res_i == RES_WIN);
      lose_q  <= (res_i == RES_LOSE);
    end
  end

endmodule

// File: rtl/coin_streak_fsm.sv
module coin_streak_fsm
  import coin_streak_pkg::*;
#(
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = $clog2(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toss_valid,
  input  logic             toss_head,
  output logic             win_o,
  output logic             lose_o,
  output logic [CNT_W-1:0] state_o
);

  toss_sym_t        toss_sym;
  logic [CNT_W-1:0] pos_next;
  result_t          res_next;

  toss_decoder u_dec (
    .valid_i (toss_valid),
    .head_i  (toss_head),
    .sym_o   (toss_sym)
  );

  streak_next #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_next (
    .cur_i (state_o),
    .sym_i (toss_sym),
    .nxt_o (pos_next),
    .res_o (res_next)
  );

  streak_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .nxt_i   (pos_next),
    .res_i   (res_next),
    .state_q (state_o),
    .win_q   (win_o),
    .lose_q  (lose_o)
  );

endmodule

// File: rtl/coin_streak_checker.sv
module coin_streak_checker #(
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = $clog2(RUN_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             toss_valid,
  input logic             toss_head,
  input logic             win_o,
  input logic             lose_o,
  input logic [CNT_W-1:0] state_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  wire head_seen = toss_valid && toss_head;
  wire tail_seen = toss_valid && !toss_head;
  wire at_last   = (state_o == LAST);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state_o == '0) && !win_o && !lose_o);

  // R2
  p_head_step_r2: assert property (@(posedge clk) disable iff (rst)
    (head_seen && !at_last) |=> (state_o == $past(state_o) + 1'b1) && !win_o && !lose_o);

  // R3
  p_head_win_r3: assert property (@(posedge clk) disable iff (rst)
    (head_seen && at_last) |=> win_o && !lose_o && (state_o == '0));

  // R4
  p_tail_lose_r4: assert property (@(posedge clk) disable iff (rst)
    tail_seen |=> lose_o && !win_o && (state_o == '0));

  // R5
  p_absent_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !toss_valid |=> $stable(state_o) && !win_o && !lose_o);

  // R6
  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({win_o, lose_o}) <= 1);

  // R8
  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    state_o <= LAST);

endmodule

bind coin_streak_fsm coin_streak_checker #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .toss_valid (toss_valid),
  .toss_head  (toss_head),
  .win_o      (win_o),
  .lose_o     (lose_o),
  .state_o    (state_o)
);

// File: tb/test_coin_streak_fsm.sv
`timescale 1ns/1ps
module test_coin_streak_fsm;

  localparam int RUN_LEN = 3;
  localparam int CNT_W   = $clog2(RUN_LEN);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             toss_valid = 1'b0;
  logic             toss_head  = 1'b0;
  logic             win_o, lose_o;
  logic [CNT_W-1:0] state_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int exp_state = 0;
  bit exp_win   = 0;
  bit exp_lose  = 0;

  always #4 clk = ~clk;

  coin_streak_fsm #(.RUN_LEN(RUN_LEN)) i_coin_streak_fsm (
    .clk(clk), .rst(rst), .toss_valid(toss_valid), .toss_head(toss_head),
    .win_o(win_o), .lose_o(lose_o), .state_o(state_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, int'(state_o), exp_state, "state");
    check(req, int'(win_o), int'(exp_win), "win");
    check(req, int'(lose_o), int'(exp_lose), "lose");
    check("R6", int'(win_o && lose_o), 0, "both results high");
    check("R8", int'(state_o <= CNT_W'(RUN_LEN - 1)), 1, "state in range");
  endtask

  // Bench model: returns requirement tag governing this toss
  function automatic string model(input bit v, input bit h);
    exp_win  = 0;
    exp_lose = 0;
    if (!v) return "R5";
    if (!h) begin
      exp_lose  = 1;
      exp_state = 0;
      return "R4";
    end
    if (exp_state == RUN_LEN - 1) begin
      exp_win   = 1;
      exp_state = 0;
      return "R3";
    end
    exp_state = exp_state + 1;
    return "R2";
  endfunction

  task automatic play(input bit v, input bit h);
    string req;
    int    prev_s;
    bit    prev_w, prev_l;
    @(negedge clk);
    toss_valid = v;
    toss_head  = h;
    prev_s = exp_state; prev_w = exp_win; prev_l = exp_lose;
    #1;
    // R7: nothing moves before the edge
    check("R7", int'(state_o), prev_s, "state before edge");
    check("R7", int'(win_o), int'(prev_w), "win before edge");
    check("R7", int'(lose_o), int'(prev_l), "lose before edge");
    req = model(v, h);
    @(posedge clk);
    #2;
    check_all(req);
  endtask

  task automatic do_reset(input bit v, input bit h);
    @(negedge clk);
    rst = 1'b1; toss_valid = v; toss_head = h;
    @(posedge clk);
    #2;
    exp_state = 0; exp_win = 0; exp_lose = 0;
    check_all("R1");
    @(negedge clk);
    rst = 1'b0; toss_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    do_reset(1'b0, 1'b0);

    // Directed game: tail, head, head, head
    play(1, 0);          // R4 lose
    play(1, 1);          // R2
    play(1, 1);          // R2
    play(1, 1);          // R3 win
    play(0, 1);          // R6 pulse drops, R5 absent with value high
    check("R6", int'(win_o), 0, "win after one cycle");

    // Absent ignores value bit in mid-game
    play(1, 1);
    play(0, 0);
    play(0, 1);
    play(1, 1);
    play(1, 0);          // tail at two heads -> lose
    play(1, 0);          // back-to-back loses
    play(1, 1); play(1, 1); play(1, 1); play(1, 1); // win then restart

    // Reset mid-game with a winning toss presented
    play(1, 1);
    do_reset(1, 1);
    play(1, 1);
    do_reset(1, 0);

    // Seeded random stream
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 5));
      play(r != 0, r >= 3);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule